// File: doc/BRIEF.md
# UART Register Front End with Prioritised Interrupt Identification

This block is the processor-facing register set of a 16550-style serial port. A host reaches eight register slots through a 3-bit address with separate read and write strobes. The meaning of a slot depends on the access direction and, for the two lowest offsets, on a divisor-access bit in the line control register. The block holds these registers:

- interrupt enables
- line control
- modem control
- scratch
- the 16-bit baud divisor

It passes FIFO control settings and one-cycle pulses to the transmit and receive paths. Those paths, the shifters, the baud generator and the FIFO storage live outside the block.

Status from the serial paths arrives on plain inputs:

- receive ready and trigger-level reached
- receive timeout
- line error event pulses
- transmitter empty flags
- four modem lines

The block latches line errors, modem line changes and the transmit-empty event as pending conditions. It raises one interrupt line while any enabled condition is pending, and codes the highest-priority source into the identification register.

Read data is combinational from the address. Read side effects (popping the receive data, clearing sticky bits) take effect at the clock edge that ends the read strobe.

Top module: `uart_regfile`

## Requirements
- R1: After reset, IER, LCR, MCR, scratch and divisor read as zero, IIR reads 0x01, and `irq` is low. LSR reads {rx_fifo_err, tx_idle, tx_empty, 0000, rx_ready}.
- R2: With LCR bit 7 clear, a read of offset 0 returns `rx_data` and pulses `rx_pop` for that cycle. A write to offset 0 pulses `tx_load` with `tx_data` equal to the written byte.
- R3: With LCR bit 7 set, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. Such accesses leave IER unchanged and give no `tx_load` or `rx_pop`.
- R4: IER (offset 1, LCR bit 7 clear) stores bits 3:0: 0 receive data, 1 transmit empty, 2 line status, 3 modem status. Bits 7:4 read zero.
- R5: LCR (offset 3) and scratch (offset 7) read back all 8 bits. LCR drives `word_len`=[1:0], `stop2`=[2], `parity`=[5:3] and `brk`=[6]. MCR (offset 4) keeps bits 4:0, drives `dtr`=[0], `rts`=[1], `out1`=[2], `out2`=[3] and `loopback`=[4], and reads bits 7:5 as zero.
- R6: A write to offset 2 sets `fifo_en` from bit 0 and `rx_trig` from bits 7:6. Bits 1 and 2 give one-cycle `rx_clr` and `tx_clr` pulses during the write. IIR bits 7:6 read 11 while `fifo_en` is 1 and 00 otherwise.
- R7: IIR bits 3:1 hold the source code of the highest enabled pending condition. In priority order the codes are line status 3, receive data 2, receive timeout 6, transmit empty 1 and modem status 0. Bits 5:4 read zero.
- R8: `irq` is high exactly when an enabled condition is pending, and IIR bit 0 is its inverse.
- R9: The transmit-empty condition is set by a rising edge of `tx_empty`, or by an IER write that turns bit 1 on while `tx_empty` is high. It is cleared by an IIR read that reports code 1 and by any write to the transmit holding register. A clear wins over a set in the same cycle.
- R10: LSR (offset 5) bits 4:1 latch `line_err` bits 3:0 and are cleared by an LSR read. An error event arriving in the same cycle as that read stays set.
- R11: MSR (offset 6) bits 7:4 show the lines {dcd, ri, dsr, cts}. Bits 0, 1 and 3 latch any change of cts, dsr and dcd. Bit 2 latches a high-to-low change of ri. An MSR read clears bits 3:0.
- R12: In loopback, the modem lines seen by MSR come from MCR: cts from rts, dsr from dtr, ri from out1 and dcd from out2.
- R13: Writes to offsets 5 and 6 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| irq | output | 1 | Interrupt request |
| rx_data | input | 8 | Byte at the head of the receive path |
| rx_ready | input | 1 | Receive data present |
| rx_avail | input | 1 | Receive trigger level reached |
| rx_timeout | input | 1 | Receive character timeout |
| line_err | input | 4 | Event pulses: overrun, parity, framing, break |
| rx_fifo_err | input | 1 | Receive FIFO holds an errored byte |
| tx_empty | input | 1 | Transmit holding storage empty |
| tx_idle | input | 1 | Holding storage and shifter both empty |
| cts | input | 1 | Clear-to-send line |
| dsr | input | 1 | Data-set-ready line |
| ri | input | 1 | Ring indicator line |
| dcd | input | 1 | Carrier detect line |
| rx_pop | output | 1 | Receive byte consumed |
| tx_load | output | 1 | Transmit byte written |
| tx_data | output | 8 | Byte to transmit |
| fifo_en | output | 1 | FIFOs enabled |
| rx_clr | output | 1 | Clear receive FIFO pulse |
| tx_clr | output | 1 | Clear transmit FIFO pulse |
| rx_trig | output | 2 | Receive trigger level select |
| word_len | output | 2 | Word length code |
| stop2 | output | 1 | Extra stop bit select |
| parity | output | 3 | Parity mode |
| brk | output | 1 | Force break |
| divisor | output | 16 | Baud divisor |
| dtr | output | 1 | Data terminal ready |
| rts | output | 1 | Request to send |
| out1 | output | 1 | User output 1 |
| out2 | output | 1 | User output 2 |
| loopback | output | 1 | Loopback mode |

## Verification
Results fall due at three different times:

- Read data and the strobed pulses (`rx_pop`, `tx_load`, `rx_clr`, `tx_clr`) are combinational. They are sampled shortly after the strobe is driven, before the edge that completes the access.
- Register writes, read-to-clear effects and latched events take effect one edge after the stimulus. The bench reads them back only after that edge.
- A modem line change reaches MSR one edge after the line or MCR value changes. That means two edges after an MCR write in loopback, so the bench inserts an idle cycle there before reading.

// File: rtl/uart_regfile.sv
module uart_regfile (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  input  logic [7:0] rx_data,
  input  logic       rx_ready,
  input  logic       rx_avail,
  input  logic       rx_timeout,
  input  logic [3:0] line_err,
  input  logic       rx_fifo_err,
  input  logic       tx_empty,
  input  logic       tx_idle,
  input  logic       cts,
  input  logic       dsr,
  input  logic       ri,
  input  logic       dcd,
  output logic       rx_pop,
  output logic       tx_load,
  output logic [7:0] tx_data,
  output logic       fifo_en,
  output logic       rx_clr,
  output logic       tx_clr,
  output logic [1:0] rx_trig,
  output logic [1:0] word_len,
  output logic       stop2,
  output logic [2:0] parity,
  output logic       brk,
  output logic [15:0] divisor,
  output logic       dtr,
  output logic       rts,
  output logic       out1,
  output logic       out2,
  output logic       loopback
);

  localparam logic [2:0] A_DATA = 3'd0, A_IEN = 3'd1, A_ID = 3'd2, A_LC = 3'd3,
                         A_MC = 3'd4, A_LS = 3'd5, A_MS = 3'd6, A_SCR = 3'd7;

  logic [3:0] ier;
  logic [7:0] lcr, spr, dll, dlm;
  logic [4:0] mcr;
  logic [3:0] lsr_err, msr_dlt, mprev, mline, m_ev;
  logic       thre_q, txe_q, fen_q;
  logic [1:0] trig_q;
  logic [2:0] code;
  logic       ls_p, rd_p, to_p, th_p, ms_p;
  logic [7:0] iir, lsr, msr;

  wire dlab   = lcr[7];
  wire wr_thr = wr_en & (addr == A_DATA) & ~dlab;
  wire wr_dll = wr_en & (addr == A_DATA) & dlab;
  wire wr_ier = wr_en & (addr == A_IEN) & ~dlab;
  wire wr_dlm = wr_en & (addr == A_IEN) & dlab;
  wire wr_fcr = wr_en & (addr == A_ID);
  wire rd_iir = rd_en & (addr == A_ID);
  wire rd_lsr = rd_en & (addr == A_LS);
  wire rd_msr = rd_en & (addr == A_MS);

  assign rx_pop  = rd_en & (addr == A_DATA) & ~dlab;
  assign tx_load = wr_thr;
  assign tx_data = wdata;
  assign rx_clr  = wr_fcr & wdata[1];
  assign tx_clr  = wr_fcr & wdata[2];
  assign fifo_en = fen_q;
  assign rx_trig = trig_q;

  assign word_len = lcr[1:0];
  assign stop2    = lcr[2];
  assign parity   = lcr[5:3];
  assign brk      = lcr[6];
  assign divisor  = {dlm, dll};
  assign dtr      = mcr[0];
  assign rts      = mcr[1];
  assign out1     = mcr[2];
  assign out2     = mcr[3];
  assign loopback = mcr[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier <= '0; lcr <= '0; spr <= '0; dll <= '0; dlm <= '0; mcr <= '0;
      fen_q <= 1'b0; trig_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_DATA: if (dlab) dll <= wdata;
        A_IEN:  if (dlab) dlm <= wdata; else ier <= wdata[3:0];
        A_ID:   begin fen_q <= wdata[0]; trig_q <= wdata[7:6]; end
        A_LC:   lcr <= wdata;
        A_MC:   mcr <= wdata[4:0];
        A_SCR:  spr <= wdata;
        default: ;
      endcase
    end
  end

  assign mline = mcr[4] ? {mcr[3], mcr[2], mcr[0], mcr[1]} : {dcd, ri, dsr, cts};
  assign m_ev  = {mline[3] ^ mprev[3], mprev[2] & ~mline[2],
                  mline[1] ^ mprev[1], mline[0] ^ mprev[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsr_err <= '0; msr_dlt <= '0; mprev <= '0;
    end else begin
      lsr_err <= (rd_lsr ? 4'b0 : lsr_err) | line_err;
      msr_dlt <= (rd_msr ? 4'b0 : msr_dlt) | m_ev;
      mprev   <= mline;
    end
  end

  assign ls_p = ier[2] & (|lsr_err);
  assign rd_p = ier[0] & rx_avail;
  assign to_p = ier[0] & rx_timeout;
  assign th_p = ier[1] & thre_q;
  assign ms_p = ier[3] & (|msr_dlt);
  assign irq  = ls_p | rd_p | to_p | th_p | ms_p;

  always_comb begin
    if (ls_p)      code = 3'd3;
    else if (rd_p) code = 3'd2;
    else if (to_p) code = 3'd6;
    else if (th_p) code = 3'd1;
    else           code = 3'd0;
  end

  wire thre_set = (tx_empty & ~txe_q) | (wr_ier & wdata[1] & ~ier[1] & tx_empty);
  wire thre_clr = wr_thr | (rd_iir & (code == 3'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thre_q <= 1'b0;
      txe_q  <= 1'b1;
    end else begin
      txe_q <= tx_empty;
      if (thre_clr)      thre_q <= 1'b0;
      else if (thre_set) thre_q <= 1'b1;
    end
  end

  assign iir = {fen_q, fen_q, 2'b00, code, ~irq};
  assign lsr = {rx_fifo_err, tx_idle, tx_empty, lsr_err, rx_ready};
  assign msr = {mline, msr_dlt};

  always_comb begin
    case (addr)
      A_DATA:  rdata = dlab ? dll : rx_data;
      A_IEN:   rdata = dlab ? dlm : {4'b0, ier};
      A_ID:    rdata = iir;
      A_LC:    rdata = lcr;
      A_MC:    rdata = {3'b0, mcr};
      A_LS:    rdata = lsr;
      A_MS:    rdata = msr;
      default: rdata = spr;
    endcase
  end

  // R10
  lsr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && line_err == 4'b0) |=> (lsr_err == 4'b0));

  // R11
  msr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_msr && m_ev == 4'b0) |=> (msr_dlt == 4'b0));

  // R9
  thre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_thr |=> !thre_q);

  // R3
  div_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DATA && dlab) |=> (divisor[7:0] == $past(wdata)));

  // R3
  ier_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_IEN && dlab) |=> $stable(ier));

  // R8
  irq_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iir && irq) |=> ($past(rdata[0]) == 1'b0));

endmodule

// File: tb/tb_uart_regfile.sv
module tb_uart_regfile;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, rdata, rx_data = 0, tx_data;
  logic irq, rx_ready = 0, rx_avail = 0, rx_timeout = 0, rx_fifo_err = 0;
  logic [3:0] line_err = 0;
  logic tx_empty = 1, tx_idle = 1, cts = 0, dsr = 0, ri = 0, dcd = 0;
  logic rx_pop, tx_load, fifo_en, rx_clr, tx_clr, stop2, brk;
  logic [1:0] rx_trig, word_len;
  logic [2:0] parity;
  logic [15:0] divisor;
  logic dtr, rts, out1, out2, loopback;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regfile dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .rx_data(rx_data),
    .rx_ready(rx_ready), .rx_avail(rx_avail), .rx_timeout(rx_timeout),
    .line_err(line_err), .rx_fifo_err(rx_fifo_err), .tx_empty(tx_empty),
    .tx_idle(tx_idle), .cts(cts), .dsr(dsr), .ri(ri), .dcd(dcd),
    .rx_pop(rx_pop), .tx_load(tx_load), .tx_data(tx_data), .fifo_en(fifo_en),
    .rx_clr(rx_clr), .tx_clr(tx_clr), .rx_trig(rx_trig), .word_len(word_len),
    .stop2(stop2), .parity(parity), .brk(brk), .divisor(divisor),
    .dtr(dtr), .rts(rts), .out1(out1), .out2(out2), .loopback(loopback));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd_en = 1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 0;
  endtask

  function automatic logic [7:0] exp_iir(input logic [3:0] ie, input logic fen,
      input logic e, input logic a, input logic t, input logic m, input logic h);
    logic [2:0] c;
    logic p;
    p = 1; c = 0;
    if (ie[2] & e)      c = 3;
    else if (ie[0] & a) c = 2;
    else if (ie[0] & t) c = 6;
    else if (ie[1] & h) c = 1;
    else if (ie[3] & m) c = 0;
    else                p = 0;
    return {fen, fen, 2'b00, c, ~p};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();

    rd(2, d); chk("R1 iir", d, 8'h01);
    chk("R1 irq", irq, 0);
    rd(1, d); chk("R1 ier", d, 0);
    rd(3, d); chk("R1 lcr", d, 0);
    rd(4, d); chk("R1 mcr", d, 0);
    rd(7, d); chk("R1 spr", d, 0);
    rd(5, d); chk("R1 lsr", d, 8'h60);
    chk("R1 divisor", divisor, 0);

    wr(1, 8'hFF);
    rd(1, d); chk("R4 ier reserved", d, 8'h0F);
    chk("R9 irq after enable", irq, 1);
    rd(2, d); chk("R9 set by enable", d, 8'h02);
    rd(2, d); chk("R9 cleared by iir read", d, 8'h01);
    wr(1, 8'h00);

    rx_data = 8'hA5; addr = 0; rd_en = 1;
    #1 chk("R2 rx read", rdata, 8'hA5); chk("R2 rx_pop", rx_pop, 1);
    @(negedge clk); rd_en = 0;
    #1 chk("R2 rx_pop end", rx_pop, 0);
    addr = 0; wdata = 8'h3C; wr_en = 1;
    #1 chk("R2 tx_load", tx_load, 1); chk("R2 tx_data", tx_data, 8'h3C);
    @(negedge clk); wr_en = 0;

    wr(3, 8'h80);
    addr = 0; wdata = 8'h34; wr_en = 1;
    #1 chk("R3 no tx_load", tx_load, 0);
    @(negedge clk); wr_en = 0;
    wr(1, 8'h12);
    chk("R3 divisor", divisor, 16'h1234);
    addr = 0; rd_en = 1;
    #1 chk("R3 dll read", rdata, 8'h34); chk("R3 no rx_pop", rx_pop, 0);
    @(negedge clk); rd_en = 0;
    rd(1, d); chk("R3 dlm read", d, 8'h12);
    wr(3, 8'h5B);
    rd(1, d); chk("R3 ier untouched", d, 8'h00);
    chk("R5 fields", {word_len, stop2, parity, brk}, {2'd3, 1'b0, 3'b011, 1'b1});
    rd(3, d); chk("R5 lcr", d, 8'h5B);
    wr(3, 8'h03);

    wr(4, 8'hFF);
    rd(4, d); chk("R5 mcr reserved", d, 8'h1F);
    chk("R5 mcr pins", {loopback, out2, out1, rts, dtr}, 5'h1F);
    step();
    rd(6, d); chk("R12 loopback on", d, 8'hFB);
    wr(4, 8'h10); step();
    rd(6, d); chk("R12 loopback lines drop", d, 8'h0F);
    wr(4, 8'h00); step();
    rd(6, d); chk("R12 loopback off", d, 8'h00);

    ri = 1; step();
    rd(6, d); chk("R11 ri rise", d, 8'h40);
    ri = 0; step();
    rd(6, d); chk("R11 ri fall", d, 8'h04);
    dcd = 1; step();
    rd(6, d); chk("R11 dcd change", d, 8'h88);
    rd(6, d); chk("R11 cleared", d, 8'h80);
    dcd = 0; step();
    rd(6, d); chk("R11 dcd fall", d, 8'h08);

    line_err = 4'b0101; step(); line_err = 0;
    rd(5, d); chk("R10 errors latched", d, 8'h6A);
    rd(5, d); chk("R10 cleared", d, 8'h60);
    addr = 5; rd_en = 1; line_err = 4'b1000;
    #1 chk("R10 read old", rdata, 8'h60);
    @(negedge clk); rd_en = 0; line_err = 0;
    rd(5, d); chk("R10 same-cycle event kept", d, 8'h70);

    wr(5, 8'hFF); wr(6, 8'hFF);
    rd(5, d); chk("R13 lsr write ignored", d, 8'h60);
    rd(6, d); chk("R13 msr write ignored", d, 8'h00);

    addr = 2; wdata = 8'hC7; wr_en = 1;
    #1 chk("R6 clear pulses", {rx_clr, tx_clr}, 2'b11);
    @(negedge clk); wr_en = 0;
    #1 chk("R6 pulses end", {rx_clr, tx_clr}, 2'b00);
    chk("R6 fifo ctl", {fifo_en, rx_trig}, 3'b111);
    rd(2, d); chk("R6 iir fifo bits", d, 8'hC1);
    wr(2, 8'h00);
    rd(2, d); chk("R6 fifo off", d, 8'h01);

    wr(1, 8'h02);
    chk("R9 pending", irq, 1);
    wr(0, 8'h11);
    rd(2, d); chk("R9 cleared by thr write", d, 8'h01);
    tx_empty = 0; step(); tx_empty = 1; step();
    rd(2, d); chk("R9 set by rise", d, 8'h02);
    rd(2, d); chk("R9 read clears", d, 8'h01);

    for (int i = 0; i < 40; i++) begin
      logic [7:0] v, l;
      v = 8'($urandom); l = 8'($urandom);
      wr(7, v); wr(3, l);
      rd(7, d); chk("R5 scratch random", d, v);
      rd(3, d); chk("R5 lcr random", d, l);
    end
    wr(3, 8'h03);

    for (int i = 0; i < 60; i++) begin
      logic [3:0] ie;
      logic fen, e, a, t, m, h;
      ie = 4'($urandom); fen = 1'($urandom);
      e = 1'($urandom); a = 1'($urandom); t = 1'($urandom);
      m = 1'($urandom); h = 1'($urandom);
      tx_empty = 0; rx_avail = 0; rx_timeout = 0; step();
      wr(0, 8'h00); rd(5, d); rd(6, d);
      wr(2, {2'($urandom), 5'b0, fen});
      wr(1, {4'b0, ie});
      line_err = e ? (4'b0001 << ($urandom % 4)) : 4'b0;
      if (m) cts = ~cts;
      tx_empty = h; rx_avail = a; rx_timeout = t;
      step(); line_err = 0;
      #1 chk("R8 irq random", irq, exp_iir(ie, fen, e, a, t, m, h) != {fen, fen, 6'h01});
      @(negedge clk);
      rd(2, d); chk("R7 iir random", d, exp_iir(ie, fen, e, a, t, m, h));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule